// File: doc/BRIEF.md
# PHY Reset and Receive-PLL Lock Sequencer

This block brings a serial PHY out of reset through its register control port and waits for the PHY's receive PLL to settle. It does not talk to the PHY directly. It hands address, write and read commands to a separate handshake master, which runs the low-level capture and acknowledge protocol and returns one response per command. That response either carries read data or reports that the master gave up waiting for an acknowledge.

After a start pulse, the sequencer waits a programmable start delay so the PHY reference clock can settle. It then selects the PHY clock-reset register and writes the reset value into it. After that it runs a bounded polling loop. Each pass waits a poll interval, selects the lane-0 output status register, reads it and tests the PLL-state bit. A set bit ends the run successfully. If every pass in the retry budget fails, the run ends with a lock error. A handshake timeout on any command ends the run at once with a handshake error. The host sees a busy flag, a one-cycle done pulse and a two-bit result code.

The command side is a valid/ready stream. A command that has been offered is held, unchanged, until it is taken. Only one command is outstanding at a time. The response side has no back-pressure: the sequencer is always ready for the single response it is waiting for, and it ignores any response that arrives while nothing is outstanding.

Top module: `phy_lock_seq`

## Requirements
- R1: While reset is held, and after it is released, `busy`, `done`, `cmd_valid` and `err_code` are all 0.
- R2: A `start` sampled high while `busy` is low is accepted. `busy` is high on the next cycle, and `err_code` reads 0 for as long as `busy` is high.
- R3: The first command becomes valid no sooner than START_DLY cycles and no later than START_DLY+3 cycles after the cycle in which `start` is accepted.
- R4: The run opens with an address command (`cmd_op` = 0) whose data is 0x7F3F. It is followed by a write command (`cmd_op` = 1) whose data is 0x0001, which sets reset bit 0.
- R5: Each lock check starts at least POLL_DLY cycles after the previous response. It is an address command with data 0x2003 followed by a read command (`cmd_op` = 2).
- R6: A read response whose bit 1 is set ends the run with `err_code` = 0. All other read-data bits have no effect.
- R7: After MAX_TRIES lock checks without bit 1, the run ends with `err_code` = 2 and issues no further command.
- R8: A response with `rsp_timeout` high, on any command, ends the run with `err_code` = 1 and issues no further command.
- R9: Once `cmd_valid` is high, it stays high with `cmd_op` and `cmd_data` stable until `cmd_ready` is high. The sequencer issues one command at a time, and it ignores `rsp_valid` when no command is outstanding.
- R10: `done` is high for exactly one cycle. `busy` goes low in that same cycle, and `err_code` then holds until the next accepted start.
- R11: A `start` sampled while `busy` is high is ignored. A `start` sampled in the `done` cycle is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request to run the reset-and-lock sequence |
| cmd_valid | output | 1 | Command offered to the handshake master |
| cmd_ready | input | 1 | Handshake master takes the command |
| cmd_op | output | 2 | Command kind: 0 address, 1 write, 2 read |
| cmd_data | output | 16 | Register address or write value |
| rsp_valid | input | 1 | One-cycle response for the outstanding command |
| rsp_timeout | input | 1 | The response reports an acknowledge timeout |
| rsp_rdata | input | 16 | Read data carried with a read response |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle end-of-sequence pulse |
| err_code | output | 2 | Result: 0 ok, 1 handshake timeout, 2 PLL never locked |

## Verification
Two events can share a clock edge, and the bench forces both. The first is the end of a run together with a new start. The bench raises `start` in the very cycle it sees `done`, then checks that `busy` is high again on the next cycle and that the second run replays the full command script from its first address command. The second is the acceptance of a command together with a stray `rsp_valid` that carries a timeout flag. The bench injects stray responses only when nothing is outstanding, some of them in the cycle a command is being taken, and judges the outcome from the command list and the final `err_code`, which must match what the bench model predicts when strays are ignored.

// File: rtl/phy_seq_pkg.sv
package phy_seq_pkg;

  typedef enum logic [1:0] {
    OP_ADDR  = 2'd0,
    OP_WRITE = 2'd1,
    OP_READ  = 2'd2
  } phy_op_e;

  typedef enum logic [1:0] {
    ERR_NONE   = 2'd0,
    ERR_HSHAKE = 2'd1,
    ERR_NOLOCK = 2'd2
  } seq_err_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_WAIT_CLK,
    S_RST_ADDR,
    S_RST_WR,
    S_POLL_WAIT,
    S_STAT_ADDR,
    S_STAT_RD
  } seq_state_e;

endpackage

// File: rtl/seq_delay_timer.sv
// Down-counter: loads a cycle count and reports when it has drained to zero.
module seq_delay_timer #(
  parameter int W = 14
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         zero
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)           cnt <= '0;
    else if (load)        cnt <= load_val;
    else if (cnt != '0)   cnt <= cnt - W'(1);
  end

  assign zero = (cnt == '0);
endmodule

// File: rtl/seq_try_counter.sv
// Counts failed lock checks; flags when the current check is the last allowed.
module seq_try_counter #(
  parameter int MAX_TRIES = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic bump,
  output logic last
);
  localparam int TW = $clog2(MAX_TRIES + 1);
  logic [TW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)     cnt <= '0;
    else if (clear) cnt <= '0;
    else if (bump)  cnt <= cnt + TW'(1);
  end

  assign last = (cnt == TW'(MAX_TRIES - 1));
endmodule

// File: rtl/seq_cmd_port.sv
// Valid/ready command source with one outstanding command and a response wait.
module seq_cmd_port #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic [1:0]    go_op,
  input  logic [DW-1:0] go_data,
  output logic          cmd_valid,
  input  logic          cmd_ready,
  output logic [1:0]    cmd_op,
  output logic [DW-1:0] cmd_data,
  input  logic          rsp_valid,
  input  logic          rsp_timeout,
  input  logic [DW-1:0] rsp_rdata,
  output logic          fin,
  output logic          fin_timeout,
  output logic [DW-1:0] fin_rdata
);
  logic waiting;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_valid <= 1'b0;
      waiting   <= 1'b0;
      cmd_op    <= '0;
      cmd_data  <= '0;
    end else begin
      if (go) begin
        cmd_valid <= 1'b1;
        cmd_op    <= go_op;
        cmd_data  <= go_data;
      end else if (cmd_valid && cmd_ready) begin
        cmd_valid <= 1'b0;
        waiting   <= 1'b1;
      end
      if (waiting && rsp_valid) waiting <= 1'b0;
    end
  end

  assign fin         = waiting && rsp_valid;
  assign fin_timeout = rsp_timeout;
  assign fin_rdata   = rsp_rdata;
endmodule

// File: rtl/phy_lock_seq.sv
module phy_lock_seq
  import phy_seq_pkg::*;
#(
  parameter int          DATA_W        = 16,
  parameter int          START_DLY     = 12500,
  parameter int          POLL_DLY      = 12500,
  parameter int          MAX_TRIES     = 10,
  parameter logic [15:0] CLKRST_REG    = 16'h7F3F,
  parameter logic [15:0] RESET_VAL     = 16'h0001,
  parameter logic [15:0] LANE_STAT_REG = 16'h2003,
  parameter int          LOCK_BIT      = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output logic [1:0]        cmd_op,
  output logic [DATA_W-1:0] cmd_data,
  input  logic              rsp_valid,
  input  logic              rsp_timeout,
  input  logic [DATA_W-1:0] rsp_rdata,
  output logic              busy,
  output logic              done,
  output logic [1:0]        err_code
);
  localparam int DLY_MAX = (START_DLY > POLL_DLY) ? START_DLY : POLL_DLY;
  localparam int DLY_W   = $clog2(DLY_MAX + 1);
  localparam logic [DATA_W-1:0] LOCK_MASK = DATA_W'(1) << LOCK_BIT;

  seq_state_e        state;
  logic              go;
  logic [1:0]        go_op;
  logic [DATA_W-1:0] go_data;
  logic              fin, fin_to;
  logic [DATA_W-1:0] fin_data;
  logic              tmr_load, tmr_zero;
  logic [DLY_W-1:0]  tmr_val;
  logic              try_clr, try_bump, try_last;
  logic              lock_seen;
  logic              unused_rdata;

  assign lock_seen    = |(fin_data & LOCK_MASK);
  assign unused_rdata = ^(fin_data & ~LOCK_MASK);

  seq_delay_timer #(.W(DLY_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val), .zero(tmr_zero)
  );

  seq_try_counter #(.MAX_TRIES(MAX_TRIES)) u_tries (
    .clk(clk), .rst_n(rst_n), .clear(try_clr), .bump(try_bump), .last(try_last)
  );

  seq_cmd_port #(.DW(DATA_W)) u_port (
    .clk(clk), .rst_n(rst_n),
    .go(go), .go_op(go_op), .go_data(go_data),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op), .cmd_data(cmd_data),
    .rsp_valid(rsp_valid), .rsp_timeout(rsp_timeout), .rsp_rdata(rsp_rdata),
    .fin(fin), .fin_timeout(fin_to), .fin_rdata(fin_data)
  );

  // Timer reloads and retry bookkeeping, decoded from the current step.
  always_comb begin
    tmr_load = 1'b0;
    tmr_val  = DLY_W'(POLL_DLY);
    try_clr  = 1'b0;
    try_bump = 1'b0;
    case (state)
      S_IDLE: if (start) begin
        tmr_load = 1'b1;
        tmr_val  = DLY_W'(START_DLY);
      end
      S_RST_WR: if (fin && !fin_to) begin
        tmr_load = 1'b1;
        try_clr  = 1'b1;
      end
      S_STAT_RD: if (fin && !fin_to && !lock_seen && !try_last) begin
        tmr_load = 1'b1;
        try_bump = 1'b1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      busy     <= 1'b0;
      done     <= 1'b0;
      err_code <= ERR_NONE;
      go       <= 1'b0;
      go_op    <= OP_ADDR;
      go_data  <= '0;
    end else begin
      go   <= 1'b0;
      done <= 1'b0;
      case (state)
        S_IDLE: if (start) begin
          busy     <= 1'b1;
          err_code <= ERR_NONE;
          state    <= S_WAIT_CLK;
        end
        S_WAIT_CLK: if (tmr_zero) begin
          go      <= 1'b1;
          go_op   <= OP_ADDR;
          go_data <= DATA_W'(CLKRST_REG);
          state   <= S_RST_ADDR;
        end
        S_RST_ADDR: if (fin) begin
          if (fin_to) begin
            err_code <= ERR_HSHAKE;
            busy     <= 1'b0;
            done     <= 1'b1;
            state    <= S_IDLE;
          end else begin
            go      <= 1'b1;
            go_op   <= OP_WRITE;
            go_data <= DATA_W'(RESET_VAL);
            state   <= S_RST_WR;
          end
        end
        S_RST_WR: if (fin) begin
          if (fin_to) begin
            err_code <= ERR_HSHAKE;
            busy     <= 1'b0;
            done     <= 1'b1;
            state    <= S_IDLE;
          end else begin
            state <= S_POLL_WAIT;
          end
        end
        S_POLL_WAIT: if (tmr_zero) begin
          go      <= 1'b1;
          go_op   <= OP_ADDR;
          go_data <= DATA_W'(LANE_STAT_REG);
          state   <= S_STAT_ADDR;
        end
        S_STAT_ADDR: if (fin) begin
          if (fin_to) begin
            err_code <= ERR_HSHAKE;
            busy     <= 1'b0;
            done     <= 1'b1;
            state    <= S_IDLE;
          end else begin
            go      <= 1'b1;
            go_op   <= OP_READ;
            go_data <= '0;
            state   <= S_STAT_RD;
          end
        end
        S_STAT_RD: if (fin) begin
          if (fin_to || lock_seen || try_last) begin
            err_code <= fin_to    ? ERR_HSHAKE :
                        lock_seen ? ERR_NONE   : ERR_NOLOCK;
            busy     <= 1'b0;
            done     <= 1'b1;
            state    <= S_IDLE;
          end else begin
            state <= S_POLL_WAIT;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/phy_lock_seq_chk.sv
module phy_lock_seq_chk #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              cmd_valid,
  input logic              cmd_ready,
  input logic [1:0]        cmd_op,
  input logic [DATA_W-1:0] cmd_data,
  input logic              busy,
  input logic              done,
  input logic [1:0]        err_code
);
  // R9: an offered command is held until taken
  a_r9_hold_valid: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_ready |=> cmd_valid);
  a_r9_hold_payload: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_ready |=> $stable(cmd_op) && $stable(cmd_data));
  // R10: done lasts one cycle and coincides with busy falling
  a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r10_busy_drop: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy && $past(busy));
  // R10: result holds while idle
  a_r10_err_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && $past(!busy) |-> $stable(err_code));
  // R2: accepted start raises busy, result reads 0 while running
  a_r2_accept: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && start |=> busy);
  a_r2_err_clear: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> err_code == 2'd0);
  // R7 / R8: no command activity outside a run
  a_r8_quiet_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !cmd_valid);
endmodule

bind phy_lock_seq phy_lock_seq_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .cmd_valid(cmd_valid),
  .cmd_ready(cmd_ready), .cmd_op(cmd_op), .cmd_data(cmd_data),
  .busy(busy), .done(done), .err_code(err_code)
);

// File: tb/phy_lock_seq_bench.sv
module phy_lock_seq_bench;
  localparam int SD = 6;
  localparam int PD = 4;
  localparam int MT = 10;

  logic        clk, rst_n, start;
  logic        cmd_valid, cmd_ready;
  logic [1:0]  cmd_op;
  logic [15:0] cmd_data;
  logic        rsp_valid, rsp_timeout;
  logic [15:0] rsp_rdata;
  logic        busy, done;
  logic [1:0]  err_code;

  phy_lock_seq #(.START_DLY(SD), .POLL_DLY(PD), .MAX_TRIES(MT)) u_phy_lock_seq (
    .clk(clk), .rst_n(rst_n), .start(start),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op), .cmd_data(cmd_data),
    .rsp_valid(rsp_valid), .rsp_timeout(rsp_timeout), .rsp_rdata(rsp_rdata),
    .busy(busy), .done(done), .err_code(err_code)
  );

  int n_checks = 0;
  int n_fail   = 0;
  int cyc      = 0;
  int to_idx, lock_at, cmd_idx, read_no, exp_n, exp_err, last_rsp_cyc;
  bit finished = 0;

  initial begin
    clk = 0;
    forever #4 clk = ~clk;
  end
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(string tag, int act, int exp, string what);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // Expected command script: idx0 addr 7F3F, idx1 write 0001, then addr 2003 / read pairs.
  function automatic void exp_cmd(int i, output int op, output int data);
    if (i == 0)          begin op = 0; data = 16'h7F3F; end
    else if (i == 1)     begin op = 1; data = 16'h0001; end
    else if (i % 2 == 0) begin op = 0; data = 16'h2003; end
    else                 begin op = 2; data = -1;       end
  endfunction

  function automatic void exp_outcome(int to, int lk, output int n, output int e);
    int reads = (lk <= MT) ? lk : MT;
    n = 2 + 2 * reads;
    e = (lk <= MT) ? 0 : 2;
    if (to >= 0 && to < n) begin n = to + 1; e = 1; end
  endfunction

  // Handshake-master model: random ready, random response latency, stray responses.
  initial begin
    bit pend = 0, pend_rd = 0;
    int lat = 0, pend_idx = 0;
    cmd_ready = 0; rsp_valid = 0; rsp_timeout = 0; rsp_rdata = 0;
    forever begin
      @(negedge clk);
      rsp_valid = 0; rsp_timeout = 0;
      if (pend) begin
        if (lat == 0) begin
          rsp_valid   = 1;
          rsp_timeout = (pend_idx == to_idx);
          rsp_rdata   = 16'($urandom) & 16'hFFFD;
          if (pend_rd && read_no >= lock_at) rsp_rdata = rsp_rdata | 16'h0002;
          pend = 0;
          last_rsp_cyc = cyc;
        end else lat--;
      end else if ($urandom_range(0, 5) == 0) begin
        rsp_valid = 1; rsp_timeout = 1; rsp_rdata = 16'hFFFF; // R9 stray, must be ignored
      end
      cmd_ready = ($urandom_range(0, 2) != 0);
      if (cmd_valid && cmd_ready) begin
        int op, data;
        if (cmd_idx >= exp_n) chk("R8", cmd_idx, exp_n - 1, "command after end of run");
        else begin
          exp_cmd(cmd_idx, op, data);
          chk(cmd_idx < 2 ? "R4" : "R5", int'(cmd_op), op, "command kind");
          if (data >= 0) chk(cmd_idx < 2 ? "R4" : "R5", int'(cmd_data), data, "command data");
          if (cmd_idx >= 2 && op == 0)
            chk("R5", int'(cyc - last_rsp_cyc >= PD), 1, "poll interval honoured");
        end
        pend = 1; pend_idx = cmd_idx; pend_rd = (cmd_op == 2'd2);
        lat = $urandom_range(0, 3);
        if (pend_rd) read_no++;
        cmd_idx++;
      end
    end
  end

  task automatic launch(int to, int lk);
    to_idx = to; lock_at = lk; cmd_idx = 0; read_no = 0;
    exp_outcome(to, lk, exp_n, exp_err);
    start = 1;
  endtask

  task automatic run_one(int to, int lk, bit started, bit poke,
                         bit chain, int nto, int nlk);
    int k = 0, w = 0;
    string rt;
    if (!started) begin
      @(negedge clk); launch(to, lk);
      @(negedge clk); start = 0;
      chk("R2", busy, 1, "busy after start");
      chk("R2", err_code, 0, "result cleared on start");
    end
    while (!cmd_valid && k < 200) begin @(negedge clk); k++; end
    chk("R3", int'(k >= SD && k <= SD + 3), 1, "start delay window");
    while (!done && w < 5000) begin
      @(negedge clk); w++;
      if (poke && w == 3) start = 1;           // R11 start while busy
      else if (poke && w == 4) start = 0;
    end
    if (!done) begin chk("R10", 0, 1, "watchdog: done never came"); return; end
    rt = (exp_err == 1) ? "R8" : (exp_err == 2) ? "R7" : "R6";
    chk(rt, err_code, exp_err, "result code");
    chk(rt, cmd_idx, exp_n, "command count");
    chk("R10", busy, 0, "busy low with done");
    if (chain) launch(nto, nlk);               // R11 start in done cycle
    @(negedge clk);
    chk("R10", done, 0, "done one cycle");
    if (chain) begin
      start = 0;
      chk("R11", busy, 1, "start in done cycle accepted");
    end else begin
      repeat (3) @(negedge clk);
      chk("R10", err_code, exp_err, "result holds");
      chk("R11", busy, 0, "no restart from ignored start");
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      chk("R10", 0, 1, "global watchdog");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    bit chained = 0;
    int to = -1, lk = 1;
    $urandom(32'h5EED_1234);
    to_idx = -1; lock_at = 1; cmd_idx = 0; read_no = 0; exp_n = 0; exp_err = 0;
    last_rsp_cyc = 0;
    rst_n = 0; start = 0;
    repeat (4) @(negedge clk);
    chk("R1", busy, 0, "busy in reset");
    chk("R1", cmd_valid, 0, "cmd_valid in reset");
    rst_n = 1;
    @(negedge clk);
    chk("R1", done, 0, "done after reset");
    chk("R1", err_code, 0, "result after reset");
    // directed corners
    run_one(-1, 1, 0, 0, 0, 0, 0);   // R6 lock on first check
    run_one(-1, 10, 0, 0, 0, 0, 0);  // R6 lock on last allowed check
    run_one(-1, 11, 0, 0, 0, 0, 0);  // R7 budget exhausted
    run_one(0, 1, 0, 0, 0, 0, 0);    // R8 timeout on first address
    run_one(1, 5, 0, 0, 0, 0, 0);    // R8 timeout on reset write
    run_one(7, 20, 0, 0, 0, 0, 0);   // R8 timeout on a status read
    run_one(-1, 3, 0, 1, 0, 0, 0);   // R11 start while busy
    run_one(-1, 2, 0, 0, 1, 3, 1);   // R11 chain into next run
    run_one(3, 1, 1, 0, 0, 0, 0);
    // constrained random
    for (int i = 0; i < 30; i++) begin
      bit ch = ($urandom_range(0, 2) == 0);
      bit pk = ($urandom_range(0, 3) == 0);
      int nto = ($urandom_range(0, 3) == 0) ? int'($urandom_range(0, 23)) : -1;
      int nlk = $urandom_range(1, 12);
      if (!chained) begin
        to = ($urandom_range(0, 3) == 0) ? int'($urandom_range(0, 23)) : -1;
        lk = $urandom_range(1, 12);
      end
      run_one(to, lk, chained, pk, ch, nto, nlk);
      chained = ch; to = nto; lk = nlk;
    end
    if (chained) run_one(to, lk, 1, 0, 0, 0, 0);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule